// File: doc/BRIEF.md
# ADC Scan Sequencer with Upper-Limit Interrupt Filter

This block runs a fixed four-conversion scan on an external analog-to-digital converter. Software writes a start code into the channel-select register. A launch request then converts the channel named by that code and the three channels above it, one after another in rising order. Each conversion gets a one-cycle start pulse. The sequencer then holds the channel number steady and waits for the converter to report a result. It stores each 10-bit result in the result register for its slot.

Each time a result arrives, its top eight bits are compared with a programmable byte limit. A range-select input decides whether a result at or below the limit raises the interrupt, or a result above it. Start codes outside the usable window are refused before any conversion begins. A reference configuration that would put a reserved channel into the scan is also refused. In both cases an error pulse is raised and no conversion starts.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the channel-select register reads 0x000, the limit register reads 0x0FF, all four result registers read 0, and `conv_start`, `irq`, `scan_done`, `scan_err` and `busy` are low.
- R2: A write to address 0 keeps write-data bits 3:0 as the start code. Bits 7:4 read back as zero.
- R3: Start code N (0 to 5), launched by `scan_go` while idle, produces four one-cycle `conv_start` pulses. The first pulse is in the cycle after the launch. Each pulse after the first comes in the cycle after the previous `conv_valid`. `conv_chan` equals N+slot for slots 0 to 3 in order.
- R4: A launch with start code 6 to 15 gives a one-cycle `scan_err` in the cycle after the launch. No `conv_start` follows and `busy` stays low.
- R5: A launch with `ext_pos_ref` high and code 0 is refused like R4. So is a launch with `ext_neg_ref` high and code 0 or 1. Code 1 with only `ext_pos_ref` high is legal, and code 2 with only `ext_neg_ref` high is legal.
- R6: The result accepted in slot s is readable at address 4+s until the next scan overwrites it.
- R7: With `range_sel` low, `irq` pulses for a slot exactly when result bits 9:2 are less than or equal to the limit register (address 1, 8 bits).
- R8: With `range_sel` high, `irq` pulses for a slot exactly when result bits 9:2 are strictly greater than the limit register.
- R9: `irq` is high for one cycle, in the cycle after the `conv_valid` it belongs to. After slot 3's `conv_valid`, `scan_done` is high for one cycle and `busy` is low in that same cycle.
- R10: A write to address 0 while `busy` is high leaves the channel-select register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 channel select, 1 limit, 4 to 7 slot results |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 10 | Read data for `reg_addr`, combinational |
| scan_go | input | 1 | Launch request, taken only while idle |
| range_sel | input | 1 | 0: interrupt at or below the limit; 1: interrupt above the limit |
| ext_pos_ref | input | 1 | External positive reference in use; channel 0 is reserved |
| ext_neg_ref | input | 1 | External negative reference in use; channel 1 is reserved |
| conv_chan | output | 4 | Channel for the current conversion |
| conv_start | output | 1 | One-cycle conversion start |
| conv_valid | input | 1 | Converter result strobe |
| conv_result | input | 10 | Converter result |
| irq | output | 1 | Per-conversion interrupt pulse |
| scan_done | output | 1 | One-cycle end-of-scan pulse |
| scan_err | output | 1 | One-cycle refused-launch pulse |
| busy | output | 1 | Scan in progress |

## Verification
Random scans use random legal start codes, limits, range settings, results and converter latencies. They check whether the channel walk follows the start code and not a fixed base, and whether results land in their own slots. Directed scans put the upper result byte exactly at the limit and one step on each side of it under both range settings. These cases separate a `<=` comparison from a `<` comparison, and a comparison on bits 9:2 from one on the low bits. Every code from 6 to 15 and each reserved-reference combination is launched, next to the neighbouring legal codes, to pin the legality boundary. A write to the channel-select register in the middle of a scan shows whether the busy guard holds.

// File: rtl/adc_scan_pkg.sv
// Package: shared sizes and the sequencer state type for the scan block.
// Assumes a 10-bit converter and a byte-wide limit taken from the top bits.
package adc_scan_pkg;
    localparam int RES_W_DEF    = 10;
    localparam int LIM_W_DEF    = 8;
    localparam int CHAN_W_DEF   = 4;
    localparam int N_SLOTS_DEF  = 4;
    localparam int MAX_CODE_DEF = 5;
    localparam int ADDR_W_DEF   = 3;
    localparam int WDATA_W_DEF  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2
    } scan_state_e;
endpackage

// File: rtl/adc_scan_regs.sv
// Module: register file for the scan block.
// Holds the channel-select code, the byte limit and one result per slot.
// Assumes results are written only by the sequencer, and only during a scan.
module adc_scan_regs #(
    parameter int CHAN_W  = adc_scan_pkg::CHAN_W_DEF,
    parameter int LIM_W   = adc_scan_pkg::LIM_W_DEF,
    parameter int RES_W   = adc_scan_pkg::RES_W_DEF,
    parameter int N_SLOTS = adc_scan_pkg::N_SLOTS_DEF,
    parameter int ADDR_W  = adc_scan_pkg::ADDR_W_DEF,
    parameter int WDATA_W = adc_scan_pkg::WDATA_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [WDATA_W-1:0]         wdata,
    input  logic                       busy,
    input  logic                       res_we,
    input  logic [$clog2(N_SLOTS)-1:0] res_slot,
    input  logic [RES_W-1:0]           res_data,
    output logic [CHAN_W-1:0]          chan_code,
    output logic [LIM_W-1:0]           limit,
    output logic [RES_W-1:0]           rdata
);
    localparam int CHAN_ADDR = 0;
    localparam int LIM_ADDR  = 1;
    localparam int RES_BASE  = N_SLOTS;

    logic [CHAN_W-1:0] chan_q;
    logic [LIM_W-1:0]  lim_q;
    logic [RES_W-1:0]  res_q [N_SLOTS];

    // Channel-select code: upper write bits dropped, writes blocked while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chan_q <= '0;
        else if (wr_en && addr == ADDR_W'(CHAN_ADDR) && !busy)
            chan_q <= wdata[CHAN_W-1:0];
    end

    // Limit register: resets to all ones, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lim_q <= '1;
        else if (wr_en && addr == ADDR_W'(LIM_ADDR))
            lim_q <= wdata[LIM_W-1:0];
    end

    // One result register per slot.
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_res
        // Slot result capture on the sequencer's write strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                res_q[s] <= '0;
            else if (res_we && res_slot == s[$clog2(N_SLOTS)-1:0])
                res_q[s] <= res_data;
        end
    end

    // Read mux over control and result registers.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CHAN_ADDR))
            rdata = RES_W'(chan_q);
        else if (addr == ADDR_W'(LIM_ADDR))
            rdata = RES_W'(lim_q);
        for (int i = 0; i < N_SLOTS; i++)
            if (addr == ADDR_W'(RES_BASE + i))
                rdata = res_q[i];
    end

    assign chan_code = chan_q;
    assign limit     = lim_q;

    // A code write that lands while a scan runs leaves the code unchanged.
    assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && addr == ADDR_W'(CHAN_ADDR)) |=> $stable(chan_code));
endmodule

// File: rtl/adc_scan_fsm.sv
// Module: scan sequencer.
// Checks a launch for legality, then walks N_SLOTS consecutive channels.
// Each slot gets one start pulse, and the slot ends on the converter's
// result strobe. Assumes the converter answers each start exactly once.
module adc_scan_fsm
    import adc_scan_pkg::*;
#(
    parameter int CHAN_W   = adc_scan_pkg::CHAN_W_DEF,
    parameter int N_SLOTS  = adc_scan_pkg::N_SLOTS_DEF,
    parameter int MAX_CODE = adc_scan_pkg::MAX_CODE_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       go,
    input  logic [CHAN_W-1:0]          code,
    input  logic                       ext_pos,
    input  logic                       ext_neg,
    input  logic                       conv_valid,
    output logic                       conv_start,
    output logic [CHAN_W-1:0]          conv_chan,
    output logic                       busy,
    output logic                       scan_err,
    output logic                       scan_done,
    output logic                       res_we,
    output logic [$clog2(N_SLOTS)-1:0] slot
);
    localparam int SLOT_W = $clog2(N_SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);
    localparam int POS_RSV_CH = 0;
    localparam int NEG_RSV_CH = 1;

    scan_state_e       state_q;
    logic [CHAN_W-1:0] base_q;
    logic [SLOT_W-1:0] slot_q;
    logic              err_q;
    logic              done_q;
    logic              launch_ok;

    // Launch legality: the code range, plus the reserved channels in the window.
    always_comb begin
        launch_ok = (code <= CHAN_W'(MAX_CODE));
        if (ext_pos && code <= CHAN_W'(POS_RSV_CH))
            launch_ok = 1'b0;
        if (ext_neg && code <= CHAN_W'(NEG_RSV_CH))
            launch_ok = 1'b0;
    end

    // Sequencer state, slot counter and one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            slot_q  <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            err_q  <= 1'b0;
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        if (launch_ok) begin
                            base_q  <= code;
                            slot_q  <= '0;
                            state_q <= ST_START;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_START: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (conv_valid) begin
                        if (slot_q == LAST_SLOT) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            slot_q  <= slot_q + 1'b1;
                            state_q <= ST_START;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign conv_start = (state_q == ST_START);
    assign conv_chan  = base_q + CHAN_W'(slot_q);
    assign busy       = (state_q != ST_IDLE);
    assign scan_err   = err_q;
    assign scan_done  = done_q;
    assign res_we     = (state_q == ST_WAIT) && conv_valid;
    assign slot       = slot_q;

    // Each start pulse lasts exactly one cycle.
    assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // The channel of a start pulse never leaves the legal window.
    assert_chan_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> conv_chan <= CHAN_W'(MAX_CODE + N_SLOTS - 1));
    // A launch with an out-of-range code is refused and stays idle.
    assert_bad_code_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go && code > CHAN_W'(MAX_CODE)) |=> (scan_err && !busy));
    // A refused launch never comes with a start pulse.
    assert_err_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scan_err |-> !conv_start);
    // The done pulse is one cycle wide, and the block is idle while it shows.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (!busy ##1 !scan_done));
endmodule

// File: rtl/adc_scan_cmp.sv
// Module: limit comparator and interrupt register.
// Compares the top LIM_W result bits with the limit on each accepted result.
// The range select picks the interrupt side. Assumes a combinational result strobe.
module adc_scan_cmp #(
    parameter int RES_W = adc_scan_pkg::RES_W_DEF,
    parameter int LIM_W = adc_scan_pkg::LIM_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_we,
    input  logic [RES_W-1:0] result,
    input  logic [LIM_W-1:0] limit,
    input  logic             range_sel,
    output logic             irq
);
    logic [LIM_W-1:0] upper;
    logic             hit;
    logic             irq_q;

    // Interrupt condition on the top result bits.
    always_comb begin
        upper = result[RES_W-1 -: LIM_W];
        hit   = range_sel ? (upper > limit) : (upper <= limit);
    end

    // Register the interrupt for a single cycle per accepted result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= res_we && hit;
    end

    assign irq = irq_q;

    // An interrupt only ever follows an accepted result.
    assert_irq_after_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(res_we));
    // With the limit at its top value and range_sel low, every result interrupts.
    assert_full_limit_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && !range_sel && limit == '1) |=> irq);
endmodule

// File: rtl/adc_scan_seq.sv
// Module: top of the scan sequencer with the upper-limit interrupt filter.
// Joins the register file, the sequencer and the comparator.
// Assumes the converter holds its result valid for one cycle per start.
module adc_scan_seq #(
    parameter int RES_W    = adc_scan_pkg::RES_W_DEF,
    parameter int LIM_W    = adc_scan_pkg::LIM_W_DEF,
    parameter int CHAN_W   = adc_scan_pkg::CHAN_W_DEF,
    parameter int N_SLOTS  = adc_scan_pkg::N_SLOTS_DEF,
    parameter int MAX_CODE = adc_scan_pkg::MAX_CODE_DEF,
    parameter int ADDR_W   = adc_scan_pkg::ADDR_W_DEF,
    parameter int WDATA_W  = adc_scan_pkg::WDATA_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WDATA_W-1:0] reg_wdata,
    output logic [RES_W-1:0]   reg_rdata,
    input  logic               scan_go,
    input  logic               range_sel,
    input  logic               ext_pos_ref,
    input  logic               ext_neg_ref,
    output logic [CHAN_W-1:0]  conv_chan,
    output logic               conv_start,
    input  logic               conv_valid,
    input  logic [RES_W-1:0]   conv_result,
    output logic               irq,
    output logic               scan_done,
    output logic               scan_err,
    output logic               busy
);
    localparam int SLOT_W = $clog2(N_SLOTS);

    logic [CHAN_W-1:0] chan_code;
    logic [LIM_W-1:0]  limit;
    logic              res_we;
    logic [SLOT_W-1:0] slot;

    adc_scan_regs #(
        .CHAN_W(CHAN_W), .LIM_W(LIM_W), .RES_W(RES_W),
        .N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .WDATA_W(WDATA_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy),
        .res_we(res_we), .res_slot(slot), .res_data(conv_result),
        .chan_code(chan_code), .limit(limit), .rdata(reg_rdata)
    );

    adc_scan_fsm #(
        .CHAN_W(CHAN_W), .N_SLOTS(N_SLOTS), .MAX_CODE(MAX_CODE)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .go(scan_go), .code(chan_code),
        .ext_pos(ext_pos_ref), .ext_neg(ext_neg_ref),
        .conv_valid(conv_valid),
        .conv_start(conv_start), .conv_chan(conv_chan),
        .busy(busy), .scan_err(scan_err), .scan_done(scan_done),
        .res_we(res_we), .slot(slot)
    );

    adc_scan_cmp #(
        .RES_W(RES_W), .LIM_W(LIM_W)
    ) i_cmp (
        .clk(clk), .rst_n(rst_n),
        .res_we(res_we), .result(conv_result),
        .limit(limit), .range_sel(range_sel),
        .irq(irq)
    );
endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [9:0] reg_rdata;
    logic       scan_go = 1'b0;
    logic       range_sel = 1'b0;
    logic       ext_pos_ref = 1'b0;
    logic       ext_neg_ref = 1'b0;
    logic [3:0] conv_chan;
    logic       conv_start;
    logic       conv_valid = 1'b0;
    logic [9:0] conv_result = '0;
    logic       irq, scan_done, scan_err, busy;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    adc_scan_seq i_adc_scan_seq (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scan_go(scan_go), .range_sel(range_sel),
        .ext_pos_ref(ext_pos_ref), .ext_neg_ref(ext_neg_ref),
        .conv_chan(conv_chan), .conv_start(conv_start),
        .conv_valid(conv_valid), .conv_result(conv_result),
        .irq(irq), .scan_done(scan_done), .scan_err(scan_err), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic bit exp_irq(input logic [9:0] res, input logic [7:0] lim, input bit rng);
        return rng ? (res[9:2] > lim) : (res[9:2] <= lim);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [9:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // One full scan with a modelled converter; res packs slot s at bits 10*s.
    task automatic run_scan(input logic [3:0] code, input bit rng, input logic [7:0] lim,
                            input logic [39:0] res, input bit write_mid);
        logic [9:0] rd;
        reg_write(3'd1, lim);
        reg_write(3'd0, {4'h0, code});
        range_sel = rng;
        @(negedge clk); scan_go = 1'b1;
        @(negedge clk); scan_go = 1'b0;
        for (int s = 0; s < 4; s++) begin
            while (!conv_start) @(negedge clk);
            chk("R3 chan", conv_chan, code + s);
            @(negedge clk);
            chk("R3 start one cycle", conv_start, 0);
            if (write_mid && s == 1) reg_write(3'd0, 8'h02);
            repeat ($urandom_range(0, 3)) @(negedge clk);
            conv_valid = 1'b1; conv_result = res[10*s +: 10];
            @(negedge clk);
            conv_valid = 1'b0;
            chk(rng ? "R8 irq" : "R7 irq", irq, exp_irq(res[10*s +: 10], lim, rng));
            if (s == 3) begin
                chk("R9 done", scan_done, 1);
                chk("R9 idle", busy, 0);
            end else begin
                chk("R9 no early done", scan_done, 0);
            end
        end
        @(negedge clk);
        chk("R9 irq one cycle", irq, 0);
        for (int s = 0; s < 4; s++) begin
            reg_read(3'(4 + s), rd);
            chk("R6 slot result", rd, res[10*s +: 10]);
        end
        if (write_mid) begin
            reg_read(3'd0, rd);
            chk("R10 code kept", rd, code);
        end
    endtask

    task automatic try_bad(input logic [3:0] code, input bit pos, input bit neg, input string req);
        reg_write(3'd0, {4'h0, code});
        ext_pos_ref = pos; ext_neg_ref = neg;
        @(negedge clk); scan_go = 1'b1;
        @(negedge clk); scan_go = 1'b0;
        chk({req, " err"}, scan_err, 1);
        chk({req, " no start"}, conv_start, 0);
        chk({req, " idle"}, busy, 0);
        @(negedge clk);
        chk({req, " err one cycle"}, scan_err, 0);
        chk({req, " still no start"}, conv_start, 0);
        ext_pos_ref = 1'b0; ext_neg_ref = 1'b0;
    endtask

    // Legal launch under a reference setting: the first start must appear.
    task automatic try_ok(input logic [3:0] code, input bit pos, input bit neg);
        ext_pos_ref = pos; ext_neg_ref = neg;
        run_scan(code, 1'b0, 8'h80, {10'h3FF, 10'h000, 10'h201, 10'h1FF}, 1'b0);
        ext_pos_ref = 1'b0; ext_neg_ref = 1'b0;
    endtask

    initial begin
        logic [9:0] rd;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(3'd0, rd); chk("R1 chan reset", rd, 10'h000);
        reg_read(3'd1, rd); chk("R1 limit reset", rd, 10'h0FF);
        for (int s = 0; s < 4; s++) begin
            reg_read(3'(4 + s), rd); chk("R1 result reset", rd, 0);
        end
        chk("R1 outputs", {conv_start, irq, scan_done, scan_err, busy}, 0);

        // R2 upper bits of the code write dropped
        reg_write(3'd0, 8'hA3);
        reg_read(3'd0, rd); chk("R2 code readback", rd, 10'h003);

        // R7/R8 boundary: upper byte at, below and above the limit
        run_scan(4'd0, 1'b0, 8'h40, {10'h104, 10'h0FF, 10'h103, 10'h100}, 1'b0);
        run_scan(4'd1, 1'b1, 8'h40, {10'h104, 10'h0FF, 10'h103, 10'h100}, 1'b0);
        run_scan(4'd5, 1'b0, 8'hFF, {10'h3FF, 10'h000, 10'h2AA, 10'h155}, 1'b0);
        run_scan(4'd2, 1'b1, 8'h00, {10'h003, 10'h004, 10'h000, 10'h3FF}, 1'b0);

        // R10 code write in the middle of a scan
        run_scan(4'd4, 1'b0, 8'h7F, {10'h1FC, 10'h200, 10'h1FF, 10'h3FC}, 1'b1);

        // R4 every out-of-range code
        for (int c = 6; c < 16; c++) try_bad(4'(c), 1'b0, 1'b0, "R4");

        // R5 reserved-channel combinations and their legal neighbours
        try_bad(4'd0, 1'b1, 1'b0, "R5 pos ch0");
        try_bad(4'd0, 1'b0, 1'b1, "R5 neg code0");
        try_bad(4'd1, 1'b0, 1'b1, "R5 neg code1");
        try_ok(4'd1, 1'b1, 1'b0);
        try_ok(4'd2, 1'b0, 1'b1);

        // Random scans
        for (int n = 0; n < 40; n++) begin
            logic [39:0] r;
            for (int s = 0; s < 4; s++) r[10*s +: 10] = 10'($urandom_range(0, 1023));
            run_scan(4'($urandom_range(0, 5)), 1'($urandom_range(0, 1)),
                     8'($urandom_range(0, 255)), r, 1'($urandom_range(0, 1)));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule